// File: doc/BRIEF.md
# Data-Ready Indication Generator

This block tells the host when a fresh three-axis sample set can be read out of a sensor's output register bank. It keeps one sticky status flag and drives two interrupt pins from it. The flag goes high on every new-data strobe and goes low when the host reads the high byte of any axis. The pins can follow that flag, or they can instead emit a pulse of fixed width that starts at each new-data strobe. The pulse is shorter in high-performance mode and longer in the other power modes.

The block sits beside the serial bus slave and the output registers. It sees each register read as a one-cycle strobe together with the 8-bit address being read. It has no data path of its own: every port is a plain control or status level, so no valid/ready handshake and no back-pressure apply. Both pulse widths are counted in clock cycles and are set by parameters. Their defaults are 15000 and 28000 cycles, which give 75 µs and 140 µs at a 200 MHz clock.

Top module: `drdy_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the status flag and both pins are 0, and the pins use latched behaviour whenever the pulsed-mode select is 0.
- R2: A new-data strobe sets the status flag, which reads 1 from the next clock cycle.
- R3: With no new-data strobe in the same cycle, a read strobe at a high-byte axis address clears the status flag from the next cycle. The high-byte addresses are 0x29 (X), 0x2B (Y) and 0x2D (Z).
- R4: The status flag keeps its value through reads of the low-byte addresses 0x28, 0x2A and 0x2C, through reads of any other address, and through cycles where the read strobe is low.
- R5: When a new-data strobe and a clearing read arrive in the same cycle, the flag is 1 in the next cycle.
- R6: With pulsed-mode select at 0, each pin whose route enable is 1 equals the status flag.
- R7: With pulsed-mode select at 1 and the high-performance flag at 1 when the strobe arrives, each routed pin is 1 for exactly HP_PULSE_CYC cycles. The pulse starts in the cycle after the strobe.
- R8: With pulsed-mode select at 1 and the high-performance flag at 0 when the strobe arrives, each routed pin is 1 for exactly LP_PULSE_CYC cycles. The pulse starts in the cycle after the strobe.
- R9: A new-data strobe that arrives while a pulse is running restarts the pulse at its full width.
- R10: In pulsed mode the status flag still latches: it stays 1 after the pulse ends, until a clearing read.
- R11: Each pin is 0 whenever its own route enable is 0, independently of the other pin.
- R12: In pulsed mode, a high-byte read clears the status flag but does not cut short a running pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| new_data_i | input | 1 | One-cycle strobe: a full three-axis sample set has been stored |
| rd_strobe_i | input | 1 | One-cycle strobe: a register read takes place |
| rd_addr_i | input | 8 | Address of the register being read |
| pulsed_mode_i | input | 1 | Pin mode select: 0 latched, 1 pulsed |
| hp_mode_i | input | 1 | High-performance power mode flag; selects the pulse width |
| int1_route_i | input | 1 | Route enable for interrupt pin 1 |
| int2_route_i | input | 1 | Route enable for interrupt pin 2 |
| drdy_status_o | output | 1 | Status flag, always latched |
| int1_o | output | 1 | Interrupt pin 1 data-ready indication |
| int2_o | output | 1 | Interrupt pin 2 data-ready indication |

## Verification
The assertions check on every cycle that the status flag sets, clears and holds as R2 to R5 require. They also check that the pins follow the flag in latched mode, that each route enable gates its pin, and that a pulse is running in the cycle after a strobe given in pulsed mode. Only the bench scenarios can show the exact pulse lengths for the two power modes, the restart of a pulse when a second strobe arrives, and that a pulse keeps running after a high-byte read while the flag stays latched after the pulse has ended.

// File: rtl/drdy_gen_pkg.sv
`timescale 1ns/1ps
package drdy_gen_pkg;

  // Number of axes held in the output register bank
  localparam int unsigned AXIS_COUNT = 3;

  // Address of the first output byte (X low); each axis takes a low byte and then a high byte
  localparam logic [7:0] OUT_FIRST_ADDR = 8'h28;

  // Pin indication modes
  typedef enum logic {
    IND_LATCHED = 1'b0,
    IND_PULSED  = 1'b1
  } ind_mode_e;

  // Address of the high byte of a given axis
  function automatic logic [7:0] axis_hi_addr(input int unsigned axis);
    return OUT_FIRST_ADDR + 8'(2 * axis + 1);
  endfunction

endpackage

// File: rtl/drdy_hi_read_detect.sv
`timescale 1ns/1ps
// Flags a register read that hits the high byte of any axis.
module drdy_hi_read_detect #(
  parameter int unsigned AXES       = 3,
  parameter logic [7:0]  FIRST_ADDR = 8'h28
) (
  input  logic       rd_strobe_i,
  input  logic [7:0] rd_addr_i,
  output logic       hit_o
);

  logic [AXES-1:0] axis_match;

  generate
    for (genvar a = 0; a < AXES; a++) begin : g_axis
      localparam logic [7:0] HI_ADDR = FIRST_ADDR + 8'(2 * a + 1);
      assign axis_match[a] = (rd_addr_i == HI_ADDR);
    end
  endgenerate

  assign hit_o = rd_strobe_i & (|axis_match);

endmodule

// File: rtl/drdy_status_latch.sv
`timescale 1ns/1ps
// Sticky data-ready flag: a set wins over a clear in the same cycle.
module drdy_status_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (set_i) begin
      flag_q <= 1'b1;
    end else if (clr_i) begin
      flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/drdy_pulse_timer.sv
`timescale 1ns/1ps
// Down-counter that stretches a start strobe into a pulse of fixed width.
// The width is chosen by the power mode at the moment of the strobe; a new
// start restarts the count at full width.
module drdy_pulse_timer #(
  parameter int unsigned HP_CYC = 15000,
  parameter int unsigned LP_CYC = 28000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic hp_i,
  output logic active_o
);

  localparam int unsigned MAX_CYC = (HP_CYC > LP_CYC) ? HP_CYC : LP_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] HP_LOAD = CNT_W'(HP_CYC);
  localparam logic [CNT_W-1:0] LP_LOAD = CNT_W'(LP_CYC);

  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
    end else if (start_i) begin
      remain_q <= hp_i ? HP_LOAD : LP_LOAD;
    end else if (remain_q != '0) begin
      remain_q <= remain_q - CNT_W'(1);
    end
  end

  assign active_o = (remain_q != '0);

endmodule

// File: rtl/drdy_pin_route.sv
`timescale 1ns/1ps
// Gates one indication onto several interrupt pins, each with its own enable.
module drdy_pin_route #(
  parameter int unsigned PINS = 2
) (
  input  logic            ind_i,
  input  logic [PINS-1:0] route_i,
  output logic [PINS-1:0] pin_o
);

  generate
    for (genvar p = 0; p < PINS; p++) begin : g_pin
      assign pin_o[p] = ind_i & route_i[p];
    end
  endgenerate

endmodule

// File: rtl/drdy_gen.sv
`timescale 1ns/1ps
// Data-ready indication generator: sticky status flag plus two interrupt
// pins that follow the flag or carry a power-mode dependent pulse.
module drdy_gen
  import drdy_gen_pkg::*;
#(
  parameter int unsigned HP_PULSE_CYC = 15000,
  parameter int unsigned LP_PULSE_CYC = 28000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       new_data_i,
  input  logic       rd_strobe_i,
  input  logic [7:0] rd_addr_i,
  input  logic       pulsed_mode_i,
  input  logic       hp_mode_i,
  input  logic       int1_route_i,
  input  logic       int2_route_i,
  output logic       drdy_status_o,
  output logic       int1_o,
  output logic       int2_o
);

  localparam int unsigned PIN_COUNT = 2;

  logic                 hi_read;
  logic                 status_flag;
  logic                 pulse_active;
  logic                 pulse_start;
  logic                 pin_ind;
  ind_mode_e            mode;
  logic [PIN_COUNT-1:0] route_vec;
  logic [PIN_COUNT-1:0] pin_vec;

  assign mode = ind_mode_e'(pulsed_mode_i);

  drdy_hi_read_detect #(
    .AXES       (AXIS_COUNT),
    .FIRST_ADDR (OUT_FIRST_ADDR)
  ) u_hi_read (
    .rd_strobe_i (rd_strobe_i),
    .rd_addr_i   (rd_addr_i),
    .hit_o       (hi_read)
  );

  drdy_status_latch u_status (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (new_data_i),
    .clr_i  (hi_read),
    .flag_o (status_flag)
  );

  // The timer only runs for strobes taken while pulsed mode is selected
  assign pulse_start = new_data_i & (mode == IND_PULSED);

  drdy_pulse_timer #(
    .HP_CYC (HP_PULSE_CYC),
    .LP_CYC (LP_PULSE_CYC)
  ) u_pulse (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (pulse_start),
    .hp_i     (hp_mode_i),
    .active_o (pulse_active)
  );

  always_comb begin
    unique case (mode)
      IND_PULSED:  pin_ind = pulse_active;
      default:     pin_ind = status_flag;
    endcase
  end

  assign route_vec = {int2_route_i, int1_route_i};

  drdy_pin_route #(
    .PINS (PIN_COUNT)
  ) u_route (
    .ind_i   (pin_ind),
    .route_i (route_vec),
    .pin_o   (pin_vec)
  );

  assign drdy_status_o = status_flag;
  assign int1_o        = pin_vec[0];
  assign int2_o        = pin_vec[1];

endmodule

// File: rtl/drdy_gen_chk.sv
`timescale 1ns/1ps
module drdy_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       new_data_i,
  input logic       rd_strobe_i,
  input logic [7:0] rd_addr_i,
  input logic       pulsed_mode_i,
  input logic       int1_route_i,
  input logic       int2_route_i,
  input logic       drdy_status_o,
  input logic       int1_o,
  input logic       int2_o
);

  logic hi_rd;
  assign hi_rd = rd_strobe_i &&
                 (rd_addr_i == 8'h29 || rd_addr_i == 8'h2B || rd_addr_i == 8'h2D);

  // R2
  set_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    new_data_i |=> drdy_status_o);

  // R3
  clear_on_hi_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_rd && !new_data_i) |=> !drdy_status_o);

  // R4
  hold_otherwise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hi_rd && !new_data_i) |=> $stable(drdy_status_o));

  // R6
  latched_pin1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulsed_mode_i && int1_route_i) |-> (int1_o == drdy_status_o));

  // R6
  latched_pin2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulsed_mode_i && int2_route_i) |-> (int2_o == drdy_status_o));

  // R11
  route1_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !int1_route_i |-> !int1_o);

  // R11
  route2_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !int2_route_i |-> !int2_o);

  // R7
  pulse_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (new_data_i && pulsed_mode_i) |=> (!pulsed_mode_i || !int1_route_i || int1_o));

endmodule

bind drdy_gen drdy_gen_chk u_drdy_gen_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .new_data_i    (new_data_i),
  .rd_strobe_i   (rd_strobe_i),
  .rd_addr_i     (rd_addr_i),
  .pulsed_mode_i (pulsed_mode_i),
  .int1_route_i  (int1_route_i),
  .int2_route_i  (int2_route_i),
  .drdy_status_o (drdy_status_o),
  .int1_o        (int1_o),
  .int2_o        (int2_o)
);

// File: tb/drdy_gen_bench.sv
`timescale 1ns/1ps
module drdy_gen_bench;

  localparam int HP = 12;
  localparam int LP = 23;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       new_data_i = 1'b0;
  logic       rd_strobe_i = 1'b0;
  logic [7:0] rd_addr_i = 8'h00;
  logic       pulsed_mode_i = 1'b0;
  logic       hp_mode_i = 1'b0;
  logic       int1_route_i = 1'b0;
  logic       int2_route_i = 1'b0;
  logic       drdy_status_o;
  logic       int1_o;
  logic       int2_o;

  always #2.5 clk = ~clk;

  drdy_gen #(.HP_PULSE_CYC(HP), .LP_PULSE_CYC(LP)) u_drdy_gen (
    .clk           (clk),
    .rst_n         (rst_n),
    .new_data_i    (new_data_i),
    .rd_strobe_i   (rd_strobe_i),
    .rd_addr_i     (rd_addr_i),
    .pulsed_mode_i (pulsed_mode_i),
    .hp_mode_i     (hp_mode_i),
    .int1_route_i  (int1_route_i),
    .int2_route_i  (int2_route_i),
    .drdy_status_o (drdy_status_o),
    .int1_o        (int1_o),
    .int2_o        (int2_o)
  );

  typedef struct {
    int    at;
    string req;
    logic  sts;
    logic  p1;
    logic  p2;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  // expectation model built from the requirements
  bit m_sts = 1'b0;
  int m_cnt = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic compare(string req, logic as, logic es, logic a1, logic e1,
                         logic a2, logic e2);
    n_chk++;
    if (as !== es || a1 !== e1 || a2 !== e2) begin
      n_bad++;
      $display("FAIL %s: got sts/int1/int2=%b%b%b expected %b%b%b (cycle %0d)",
               req, as, a1, a2, es, e1, e2, cyc);
    end
  endtask

  // monitor: pops items that are due in this cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= cyc) begin
      exp_t e;
      e = q.pop_front();
      compare(e.req, drdy_status_o, e.sts, int1_o, e.p1, int2_o, e.p2);
    end
  end

  // driver: applies one cycle of stimulus and queues the expected result
  task automatic step(string tag, bit nd, bit rd, logic [7:0] ad,
                      bit pm, bit hp, bit r1, bit r2);
    bit   hi;
    bit   ind;
    exp_t e;
    @(posedge clk);
    #3;
    new_data_i    = nd;
    rd_strobe_i   = rd;
    rd_addr_i     = ad;
    pulsed_mode_i = pm;
    hp_mode_i     = hp;
    int1_route_i  = r1;
    int2_route_i  = r2;
    hi = rd && (ad == 8'h29 || ad == 8'h2B || ad == 8'h2D);
    if (nd) m_sts = 1'b1;
    else if (hi) m_sts = 1'b0;
    if (nd && pm) m_cnt = hp ? HP : LP;
    else if (m_cnt > 0) m_cnt--;
    ind = pm ? (m_cnt > 0) : m_sts;
    e.at  = cyc + 1;
    e.req = tag;
    e.sts = m_sts;
    e.p1  = r1 & ind;
    e.p2  = r2 & ind;
    q.push_back(e);
  endtask

  task automatic idle(string tag, int n, bit pm, bit hp);
    for (int i = 0; i < n; i++) step(tag, 0, 0, 8'h00, pm, hp, 1, 1);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset state, sampled while reset is held
    int1_route_i = 1'b1;
    int2_route_i = 1'b1;
    new_data_i   = 1'b1;
    repeat (3) @(negedge clk);
    compare("R1", drdy_status_o, 1'b0, int1_o, 1'b0, int2_o, 1'b0);
    @(posedge clk);
    #3;
    new_data_i = 1'b0;
    rst_n = 1'b1;
    idle("R1", 2, 0, 0);

    // R2 / R6: latched set, both pins routed
    step("R2", 1, 0, 8'h00, 0, 0, 1, 1);
    idle("R6", 1, 0, 0);

    // R4: low bytes, unrelated address, strobe low on a high address
    step("R4", 0, 1, 8'h28, 0, 0, 1, 1);
    step("R4", 0, 1, 8'h2A, 0, 0, 1, 1);
    step("R4", 0, 1, 8'h2C, 0, 0, 1, 1);
    step("R4", 0, 1, 8'h30, 0, 0, 1, 1);
    step("R4", 0, 0, 8'h29, 0, 0, 1, 1);

    // R3: each high byte clears
    step("R3", 0, 1, 8'h2B, 0, 0, 1, 1);
    step("R3", 1, 0, 8'h00, 0, 0, 1, 1);
    step("R3", 0, 1, 8'h29, 0, 0, 1, 1);
    step("R3", 1, 0, 8'h00, 0, 0, 1, 1);
    step("R3", 0, 1, 8'h2D, 0, 0, 1, 1);
    step("R4", 0, 1, 8'h2D, 0, 0, 1, 1);

    // R5: set wins over clear
    step("R5", 1, 1, 8'h29, 0, 0, 1, 1);
    idle("R5", 1, 0, 0);

    // R11: independent route enables
    step("R11", 0, 0, 8'h00, 0, 0, 1, 0);
    step("R11", 0, 0, 8'h00, 0, 0, 0, 1);
    step("R11", 0, 0, 8'h00, 0, 0, 0, 0);
    step("R3", 0, 1, 8'h2B, 0, 0, 1, 1);

    // R7: high-performance pulse width
    step("R7", 1, 0, 8'h00, 1, 1, 1, 1);
    idle("R7", HP + 3, 1, 1);

    // R10: flag still latched after the pulse
    step("R10", 0, 0, 8'h00, 1, 1, 1, 1);
    step("R10", 0, 1, 8'h2D, 1, 1, 1, 1);

    // R8: low-power pulse width
    step("R8", 1, 0, 8'h00, 1, 0, 1, 1);
    idle("R8", LP + 3, 1, 0);

    // R9: restart during a pulse
    step("R9", 1, 0, 8'h00, 1, 1, 1, 1);
    idle("R9", 5, 1, 1);
    step("R9", 1, 0, 8'h00, 1, 1, 1, 1);
    idle("R9", HP + 3, 1, 1);

    // R12: high-byte read mid-pulse does not end it
    step("R12", 1, 0, 8'h00, 1, 0, 1, 1);
    idle("R12", 3, 1, 0);
    step("R12", 0, 1, 8'h2B, 1, 0, 1, 1);
    idle("R12", LP, 1, 0);

    // back to latched, R6 with pin 2 only
    step("R6", 1, 0, 8'h00, 0, 0, 0, 1);
    idle("R6", 2, 0, 0);

    repeat (3) @(posedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule